// File: doc/BRIEF.md
# IO Address Translation Cache

This block is a small, fully associative cache of address translations for an IO memory-management unit. Each entry maps a device-visible page number to a physical page number under a set of context tags: a guest-stage valid flag, a process-context valid flag, a guest context ID and a process context ID. It also stores a bundle of permission and attribute bits and a flag marking the translation as one that targets a message-signalled interrupt. Both page numbers are held in naturally aligned power-of-two (NAPOT) form, so one entry covers a superpage of any power-of-two size, and lookups match it by ignoring the low-order bits the encoding marks.

The fill side receives every completed table walk. A policy stage decides whether the result may be cached. It looks at the request kind (untranslated access or ATS translation request), the interrupt flag, whether the interrupt is in interrupt-file mode, the guest-address-return mode of the request and two fill switches. When the result is cached, the stage picks the tag. A lookup is combinational against the registered table. The lookup port returns hit, the rebuilt physical page, the superpage flag, the attribute bits and the interrupt flag. A lookup that hits, and any fill, marks the entry most recently used. A victim is chosen by least recent use, with free entries taken first.

Top module: `iotc_cache`

## Requirements
- R1: After reset, and in the cycle after `flushAll` is high, no lookup hits. A fill presented in the same cycle as `flushAll` is dropped and `fillTaken` is low.
- R2: A lookup hits only a valid entry whose stored GV, PSCV, GSCID and PSCID all equal the lookup's values and whose page tag matches.
- R3: A fill with size order k (page count 2^k, k < VPN_W) covers the 2^k aligned pages that contain `walkVpn`; the low k bits of `walkVpn` are ignored. `lkSuper` is 1 on a hit exactly when k > 0.
- R4: On a hit, `lkPpn` carries the bits of `walkPpn` above bit k-1 (low k bits cleared) with the low k bits taken from `lkVpn`.
- R5: On a hit, `lkAttr` and `lkMsi` return the values presented with the fill.
- R6: An untranslated walk (`walkAts`=0) is cached unless both `walkMsi` and `walkMrif` are 1.
- R7: An ATS walk (`walkAts`=1) is cached only when `cfgFillAlways` is 1, or `walkT2gpa` and `cfgFillT2gpa` are both 1. The MSI exclusion of R6 still applies.
- R8: An ATS fill with `walkT2gpa`=1 is tagged with `walkGpn` in place of `walkVpn`, and its PSCV and PSCID are stored as 0.
- R9: A fill goes to the lowest-indexed invalid entry. With all entries valid, it replaces the entry used least recently, where every fill and every lookup hit counts as a use.
- R10: A lookup in the same cycle as a fill sees the table as it was before the fill. In that cycle only the filled entry becomes most recent; the hit's recency update is dropped.
- R11: `lkHit` is 0 whenever `lkValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flushAll | input | 1 | Invalidate every entry |
| walkDone | input | 1 | A walk result is presented this cycle |
| walkAts | input | 1 | 1 = ATS translation request, 0 = untranslated access |
| walkT2gpa | input | 1 | Request is in guest-address-return mode |
| walkMsi | input | 1 | Result is an interrupt translation |
| walkMrif | input | 1 | Interrupt translation is in interrupt-file mode |
| cfgFillT2gpa | input | 1 | Allow caching of guest-address-return ATS results |
| cfgFillAlways | input | 1 | Allow caching of all ATS results |
| walkVpn | input | VPN_W | Device page number of the walk |
| walkGpn | input | VPN_W | Guest physical page number of the walk |
| walkPpn | input | PPN_W | Physical page number of the walk |
| walkSizeLog | input | SZ_W | log2 of the page size in base pages |
| walkGv | input | 1 | Guest context valid |
| walkPscv | input | 1 | Process context valid |
| walkGscid | input | GSCID_W | Guest context ID |
| walkPscid | input | PSCID_W | Process context ID |
| walkAttr | input | ATTR_W | Permission and attribute bits |
| fillTaken | output | 1 | The presented walk is written this cycle |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | VPN_W | Lookup page number |
| lkGv | input | 1 | Lookup guest context valid |
| lkPscv | input | 1 | Lookup process context valid |
| lkGscid | input | GSCID_W | Lookup guest context ID |
| lkPscid | input | PSCID_W | Lookup process context ID |
| lkHit | output | 1 | Lookup hit |
| lkPpn | output | PPN_W | Rebuilt physical page number |
| lkSuper | output | 1 | Hit entry is a superpage |
| lkAttr | output | ATTR_W | Attribute bits of the hit entry |
| lkMsi | output | 1 | Hit entry is an interrupt translation |

## Verification
A fill and a lookup can land in the same cycle, and the two contend for the recency state as well as the table. The bench fills the table, then presents a fill together with a lookup. In one case the lookup hits the very entry the fill evicts, and it must still return that entry's old translation. In the other case it hits a different entry. A following fill must then evict that entry, which shows the dropped recency update. Flush against fill in the same cycle is provoked as well, and the result is judged by a lookup that must miss.

// File: rtl/iotc_pkg.sv
package iotc_pkg;

  // Strobes from the control side to the datapath and the recency tracker
  typedef struct packed {
    logic fill;      // write the victim entry with the fill payload
    logic flush;     // clear every valid bit
    logic touchHit;  // mark the hit entry most recent
  } iotc_strobe_t;

  typedef enum logic {
    REQ_UNTRANSLATED = 1'b0,
    REQ_ATS          = 1'b1
  } iotc_req_e;

endpackage

// File: rtl/iotc_ctrl.sv
module iotc_ctrl
  import iotc_pkg::*;
#(
  parameter int VPN_W   = 27,
  parameter int PPN_W   = 44,
  parameter int PSCID_W = 20,
  parameter int SZ_W    = 5
) (
  input  logic               walkDone,
  input  logic               walkAts,
  input  logic               walkT2gpa,
  input  logic               walkMsi,
  input  logic               walkMrif,
  input  logic               cfgFillT2gpa,
  input  logic               cfgFillAlways,
  input  logic [VPN_W-1:0]   walkVpn,
  input  logic [VPN_W-1:0]   walkGpn,
  input  logic [PPN_W-1:0]   walkPpn,
  input  logic [SZ_W-1:0]    walkSizeLog,
  input  logic               walkPscv,
  input  logic [PSCID_W-1:0] walkPscid,
  input  logic               flushAll,
  input  logic               anyHit,
  output iotc_strobe_t       strobe,
  output logic [VPN_W-1:0]   fillTag,
  output logic [PPN_W-1:0]   fillPpn,
  output logic               fillSuper,
  output logic               fillPscv,
  output logic [PSCID_W-1:0] fillPscid,
  output logic               fillTaken
);

  // NAPOT form: clear the low k bits, then set the low k-1 bits
  function automatic logic [VPN_W-1:0] napotVpn(input logic [VPN_W-1:0] a,
                                                input logic [SZ_W-1:0]  k);
    logic [VPN_W-1:0] low;
    low = (VPN_W'(1) << k) - VPN_W'(1);
    return (a & ~low) | (low >> 1);
  endfunction

  function automatic logic [PPN_W-1:0] napotPpn(input logic [PPN_W-1:0] a,
                                                input logic [SZ_W-1:0]  k);
    logic [PPN_W-1:0] low;
    low = (PPN_W'(1) << k) - PPN_W'(1);
    return (a & ~low) | (low >> 1);
  endfunction

  iotc_req_e reqKind;
  logic      msiAllowed;
  logic      atsAllowed;
  logic      policyOk;
  logic      useGuestTag;

  always_comb begin
    reqKind     = walkAts ? REQ_ATS : REQ_UNTRANSLATED;
    msiAllowed  = !(walkMsi && walkMrif);
    atsAllowed  = cfgFillAlways || (walkT2gpa && cfgFillT2gpa);
    policyOk    = msiAllowed && ((reqKind == REQ_UNTRANSLATED) || atsAllowed);
    useGuestTag = (reqKind == REQ_ATS) && walkT2gpa;
  end

  assign fillTaken = walkDone && policyOk && !flushAll;

  always_comb begin
    fillTag   = napotVpn(useGuestTag ? walkGpn : walkVpn, walkSizeLog);
    fillPpn   = napotPpn(walkPpn, walkSizeLog);
    fillSuper = (walkSizeLog != '0);
    fillPscv  = useGuestTag ? 1'b0 : walkPscv;
    fillPscid = useGuestTag ? '0 : walkPscid;
  end

  always_comb begin
    strobe.fill     = fillTaken;
    strobe.flush    = flushAll;
    strobe.touchHit = anyHit && !fillTaken && !flushAll;
  end

endmodule

// File: rtl/iotc_lru.sv
module iotc_lru
  import iotc_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] hitOh,
  input  iotc_strobe_t       strobe,
  output logic [ENTRIES-1:0] victimOh
);

  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // rank 0 = most recent, ENTRIES-1 = least recent; always a permutation
  logic [IDX_W-1:0]   rank [ENTRIES];
  logic [ENTRIES-1:0] touchVec;
  logic [IDX_W-1:0]   touchedRank;

  always_comb begin
    logic found;
    found    = 1'b0;
    victimOh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!validVec[i] && !found) begin
        victimOh[i] = 1'b1;
        found       = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rank[i] == OLDEST) victimOh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    if (strobe.fill)          touchVec = victimOh;
    else if (strobe.touchHit) touchVec = hitOh;
    else                      touchVec = '0;
  end

  always_comb begin
    touchedRank = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (touchVec[i]) touchedRank = touchedRank | rank[i];
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gRank
    logic [IDX_W-1:0] rankQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rankQ <= IDX_W'(g);
      end else if (|touchVec) begin
        if (touchVec[g])                rankQ <= '0;
        else if (rankQ < touchedRank)   rankQ <= rankQ + IDX_W'(1);
      end
    end
    assign rank[g] = rankQ;
  end

endmodule

// File: rtl/iotc_datapath.sv
module iotc_datapath
  import iotc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 27,
  parameter int PPN_W   = 44,
  parameter int GSCID_W = 16,
  parameter int PSCID_W = 20,
  parameter int ATTR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  iotc_strobe_t       strobe,
  input  logic [ENTRIES-1:0] victimOh,
  input  logic [VPN_W-1:0]   fillTag,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic               fillSuper,
  input  logic               fillGv,
  input  logic               fillPscv,
  input  logic [GSCID_W-1:0] fillGscid,
  input  logic [PSCID_W-1:0] fillPscid,
  input  logic [ATTR_W-1:0]  fillAttr,
  input  logic               fillMsi,
  input  logic               lkValid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic               lkGv,
  input  logic               lkPscv,
  input  logic [GSCID_W-1:0] lkGscid,
  input  logic [PSCID_W-1:0] lkPscid,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] hitOh,
  output logic [PPN_W-1:0]   lkPpn,
  output logic               lkSuper,
  output logic [ATTR_W-1:0]  lkAttr,
  output logic               lkMsi
);

  typedef struct packed {
    logic [VPN_W-1:0]   tag;
    logic [PPN_W-1:0]   ppn;
    logic               sup;
    logic               gv;
    logic               pscv;
    logic [GSCID_W-1:0] gscid;
    logic [PSCID_W-1:0] pscid;
    logic [ATTR_W-1:0]  attr;
    logic               msi;
  } entry_t;

  logic [PPN_W-1:0]  ppnOut  [ENTRIES];
  logic [ATTR_W-1:0] attrOut [ENTRIES];
  logic [ENTRIES-1:0] supOut;
  logic [ENTRIES-1:0] msiOut;

  logic [PPN_W-1:0] lkVpnWide;
  assign lkVpnWide = PPN_W'(lkVpn);

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic             validQ;
    entry_t           ent;
    logic             writeEn;
    logic [VPN_W-1:0] vpnLowMask;
    logic [PPN_W-1:0] ppnLowMask;
    logic             ctxMatch;
    logic             pageMatch;

    assign writeEn = strobe.fill && victimOh[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             validQ <= 1'b0;
      else if (strobe.flush) validQ <= 1'b0;
      else if (writeEn)      validQ <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (writeEn) begin
        ent.tag   <= fillTag;
        ent.ppn   <= fillPpn;
        ent.sup   <= fillSuper;
        ent.gv    <= fillGv;
        ent.pscv  <= fillPscv;
        ent.gscid <= fillGscid;
        ent.pscid <= fillPscid;
        ent.attr  <= fillAttr;
        ent.msi   <= fillMsi;
      end
    end

    // Low mask covers every bit up to and including the lowest zero
    always_comb begin
      vpnLowMask = ent.sup ? (ent.tag ^ (ent.tag + VPN_W'(1))) : '0;
      ppnLowMask = ent.sup ? (ent.ppn ^ (ent.ppn + PPN_W'(1))) : '0;
      ctxMatch   = (ent.gv == lkGv) && (ent.pscv == lkPscv) &&
                   (ent.gscid == lkGscid) && (ent.pscid == lkPscid);
      pageMatch  = ((lkVpn ^ ent.tag) & ~vpnLowMask) == '0;
    end

    assign validVec[g] = validQ;
    assign hitOh[g]    = lkValid && validQ && ctxMatch && pageMatch;
    assign ppnOut[g]   = (ent.ppn & ~ppnLowMask) | (lkVpnWide & ppnLowMask);
    assign attrOut[g]  = ent.attr;
    assign supOut[g]   = ent.sup;
    assign msiOut[g]   = ent.msi;
  end

  always_comb begin
    lkPpn   = '0;
    lkAttr  = '0;
    lkSuper = 1'b0;
    lkMsi   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitOh[i]) begin
        lkPpn   = lkPpn | ppnOut[i];
        lkAttr  = lkAttr | attrOut[i];
        lkSuper = lkSuper | supOut[i];
        lkMsi   = lkMsi | msiOut[i];
      end
    end
  end

endmodule

// File: rtl/iotc_cache.sv
module iotc_cache
  import iotc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 27,
  parameter int PPN_W   = 44,
  parameter int GSCID_W = 16,
  parameter int PSCID_W = 20,
  parameter int ATTR_W  = 8,
  localparam int SZ_W   = $clog2(VPN_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flushAll,
  input  logic               walkDone,
  input  logic               walkAts,
  input  logic               walkT2gpa,
  input  logic               walkMsi,
  input  logic               walkMrif,
  input  logic               cfgFillT2gpa,
  input  logic               cfgFillAlways,
  input  logic [VPN_W-1:0]   walkVpn,
  input  logic [VPN_W-1:0]   walkGpn,
  input  logic [PPN_W-1:0]   walkPpn,
  input  logic [SZ_W-1:0]    walkSizeLog,
  input  logic               walkGv,
  input  logic               walkPscv,
  input  logic [GSCID_W-1:0] walkGscid,
  input  logic [PSCID_W-1:0] walkPscid,
  input  logic [ATTR_W-1:0]  walkAttr,
  output logic               fillTaken,
  input  logic               lkValid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic               lkGv,
  input  logic               lkPscv,
  input  logic [GSCID_W-1:0] lkGscid,
  input  logic [PSCID_W-1:0] lkPscid,
  output logic               lkHit,
  output logic [PPN_W-1:0]   lkPpn,
  output logic               lkSuper,
  output logic [ATTR_W-1:0]  lkAttr,
  output logic               lkMsi
);

  iotc_strobe_t       strobe;
  logic [VPN_W-1:0]   fillTag;
  logic [PPN_W-1:0]   fillPpn;
  logic               fillSuper;
  logic               fillPscv;
  logic [PSCID_W-1:0] fillPscid;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] hitOh;
  logic [ENTRIES-1:0] victimOh;
  logic               anyHit;

  assign anyHit = |hitOh;
  assign lkHit  = anyHit;

  iotc_ctrl #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .PSCID_W(PSCID_W), .SZ_W(SZ_W)
  ) u_ctrl (
    .walkDone(walkDone), .walkAts(walkAts), .walkT2gpa(walkT2gpa),
    .walkMsi(walkMsi), .walkMrif(walkMrif),
    .cfgFillT2gpa(cfgFillT2gpa), .cfgFillAlways(cfgFillAlways),
    .walkVpn(walkVpn), .walkGpn(walkGpn), .walkPpn(walkPpn),
    .walkSizeLog(walkSizeLog), .walkPscv(walkPscv), .walkPscid(walkPscid),
    .flushAll(flushAll), .anyHit(anyHit),
    .strobe(strobe), .fillTag(fillTag), .fillPpn(fillPpn),
    .fillSuper(fillSuper), .fillPscv(fillPscv), .fillPscid(fillPscid),
    .fillTaken(fillTaken)
  );

  iotc_lru #(
    .ENTRIES(ENTRIES)
  ) u_lru (
    .clk(clk), .rstN(rstN), .validVec(validVec), .hitOh(hitOh),
    .strobe(strobe), .victimOh(victimOh)
  );

  iotc_datapath #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
    .GSCID_W(GSCID_W), .PSCID_W(PSCID_W), .ATTR_W(ATTR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .victimOh(victimOh),
    .fillTag(fillTag), .fillPpn(fillPpn), .fillSuper(fillSuper),
    .fillGv(walkGv), .fillPscv(fillPscv), .fillGscid(walkGscid),
    .fillPscid(fillPscid), .fillAttr(walkAttr), .fillMsi(walkMsi),
    .lkValid(lkValid), .lkVpn(lkVpn), .lkGv(lkGv), .lkPscv(lkPscv),
    .lkGscid(lkGscid), .lkPscid(lkPscid),
    .validVec(validVec), .hitOh(hitOh), .lkPpn(lkPpn),
    .lkSuper(lkSuper), .lkAttr(lkAttr), .lkMsi(lkMsi)
  );

endmodule

// File: rtl/iotc_checker.sv
module iotc_checker #(
  parameter int VPN_W   = 27,
  parameter int GSCID_W = 16,
  parameter int PSCID_W = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               flushAll,
  input logic               walkDone,
  input logic               walkAts,
  input logic               walkT2gpa,
  input logic               walkMsi,
  input logic               walkMrif,
  input logic               cfgFillT2gpa,
  input logic               cfgFillAlways,
  input logic [VPN_W-1:0]   walkVpn,
  input logic               walkGv,
  input logic               walkPscv,
  input logic [GSCID_W-1:0] walkGscid,
  input logic [PSCID_W-1:0] walkPscid,
  input logic               fillTaken,
  input logic               lkValid,
  input logic [VPN_W-1:0]   lkVpn,
  input logic               lkGv,
  input logic               lkPscv,
  input logic [GSCID_W-1:0] lkGscid,
  input logic [PSCID_W-1:0] lkPscid,
  input logic               lkHit
);

  // Record of the previous cycle's untranslated fill
  logic               prevFill;
  logic [VPN_W-1:0]   prevVpn;
  logic               prevGv;
  logic               prevPscv;
  logic [GSCID_W-1:0] prevGscid;
  logic [PSCID_W-1:0] prevPscid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFill  <= 1'b0;
      prevVpn   <= '0;
      prevGv    <= 1'b0;
      prevPscv  <= 1'b0;
      prevGscid <= '0;
      prevPscid <= '0;
    end else begin
      prevFill  <= fillTaken && !walkAts;
      prevVpn   <= walkVpn;
      prevGv    <= walkGv;
      prevPscv  <= walkPscv;
      prevGscid <= walkGscid;
      prevPscid <= walkPscid;
    end
  end

  a_r1_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !lkHit);

  a_r1_flush_drops_fill: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> !fillTaken);

  a_r11_idle_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> !lkHit);

  a_r6_untranslated_fills: assert property (@(posedge clk) disable iff (!rstN)
    (walkDone && !walkAts && !(walkMsi && walkMrif) && !flushAll) |-> fillTaken);

  a_r6_mrif_excluded: assert property (@(posedge clk) disable iff (!rstN)
    fillTaken |-> (walkDone && !(walkMsi && walkMrif)));

  a_r7_ats_gate: assert property (@(posedge clk) disable iff (!rstN)
    (fillTaken && walkAts) |-> (cfgFillAlways || (walkT2gpa && cfgFillT2gpa)));

  a_r2_fill_visible: assert property (@(posedge clk) disable iff (!rstN)
    (prevFill && lkValid && (lkVpn == prevVpn) && (lkGv == prevGv) &&
     (lkPscv == prevPscv) && (lkGscid == prevGscid) && (lkPscid == prevPscid))
    |-> lkHit);

endmodule

bind iotc_cache iotc_checker #(
  .VPN_W(VPN_W), .GSCID_W(GSCID_W), .PSCID_W(PSCID_W)
) u_chk (
  .clk(clk), .rstN(rstN), .flushAll(flushAll), .walkDone(walkDone),
  .walkAts(walkAts), .walkT2gpa(walkT2gpa), .walkMsi(walkMsi),
  .walkMrif(walkMrif), .cfgFillT2gpa(cfgFillT2gpa),
  .cfgFillAlways(cfgFillAlways), .walkVpn(walkVpn), .walkGv(walkGv),
  .walkPscv(walkPscv), .walkGscid(walkGscid), .walkPscid(walkPscid),
  .fillTaken(fillTaken), .lkValid(lkValid), .lkVpn(lkVpn), .lkGv(lkGv),
  .lkPscv(lkPscv), .lkGscid(lkGscid), .lkPscid(lkPscid), .lkHit(lkHit)
);

// File: tb/sim_iotc_cache.sv
module sim_iotc_cache;

  localparam int ENTRIES = 4;
  localparam int VPN_W   = 8;
  localparam int PPN_W   = 10;
  localparam int GSCID_W = 3;
  localparam int PSCID_W = 4;
  localparam int ATTR_W  = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rstN = 1'b0;
  logic               flushAll = 0, walkDone = 0, walkAts = 0, walkT2gpa = 0;
  logic               walkMsi = 0, walkMrif = 0, cfgFillT2gpa = 0, cfgFillAlways = 0;
  logic [VPN_W-1:0]   walkVpn = '0, walkGpn = '0;
  logic [PPN_W-1:0]   walkPpn = '0;
  logic [2:0]         walkSizeLog = '0;
  logic               walkGv = 0, walkPscv = 0;
  logic [GSCID_W-1:0] walkGscid = '0;
  logic [PSCID_W-1:0] walkPscid = '0;
  logic [ATTR_W-1:0]  walkAttr = '0;
  logic               fillTaken;
  logic               lkValid = 0;
  logic [VPN_W-1:0]   lkVpn = '0;
  logic               lkGv = 0, lkPscv = 0;
  logic [GSCID_W-1:0] lkGscid = '0;
  logic [PSCID_W-1:0] lkPscid = '0;
  logic               lkHit, lkSuper, lkMsi;
  logic [PPN_W-1:0]   lkPpn;
  logic [ATTR_W-1:0]  lkAttr;

  iotc_cache #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
    .GSCID_W(GSCID_W), .PSCID_W(PSCID_W), .ATTR_W(ATTR_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .walkDone(walkDone),
    .walkAts(walkAts), .walkT2gpa(walkT2gpa), .walkMsi(walkMsi),
    .walkMrif(walkMrif), .cfgFillT2gpa(cfgFillT2gpa),
    .cfgFillAlways(cfgFillAlways), .walkVpn(walkVpn), .walkGpn(walkGpn),
    .walkPpn(walkPpn), .walkSizeLog(walkSizeLog), .walkGv(walkGv),
    .walkPscv(walkPscv), .walkGscid(walkGscid), .walkPscid(walkPscid),
    .walkAttr(walkAttr), .fillTaken(fillTaken), .lkValid(lkValid),
    .lkVpn(lkVpn), .lkGv(lkGv), .lkPscv(lkPscv), .lkGscid(lkGscid),
    .lkPscid(lkPscid), .lkHit(lkHit), .lkPpn(lkPpn), .lkSuper(lkSuper),
    .lkAttr(lkAttr), .lkMsi(lkMsi)
  );

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  logic             gHit, gSup, gMsi, gTaken;
  logic [PPN_W-1:0] gPpn;
  logic [ATTR_W-1:0] gAttr;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic capture();
    gHit = lkHit; gPpn = lkPpn; gSup = lkSuper; gAttr = lkAttr; gMsi = lkMsi;
  endtask

  // keep=1 holds the lookup across a rising edge so it counts as a use
  task automatic look(input logic [VPN_W-1:0] v, input bit keep);
    @(negedge clk);
    lkValid = 1'b1;
    lkVpn   = v;
    #1 capture();
    if (keep) @(posedge clk);
    #1 lkValid = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                      input logic [2:0] k);
    @(negedge clk);
    walkVpn = v; walkPpn = p; walkSizeLog = k; walkDone = 1'b1;
    #1 gTaken = fillTaken;
    @(negedge clk);
    walkDone = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    flushAll = 1'b1;
    @(negedge clk);
    flushAll = 1'b0;
  endtask

  task automatic fillLook(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                          input logic [VPN_W-1:0] lv);
    @(negedge clk);
    walkVpn = v; walkPpn = p; walkSizeLog = '0; walkDone = 1'b1;
    lkValid = 1'b1; lkVpn = lv;
    #1 capture();
    gTaken = fillTaken;
    @(negedge clk);
    walkDone = 1'b0; lkValid = 1'b0;
  endtask

  task automatic fillFour();
    flush();
    for (int i = 0; i < 4; i++) fill(VPN_W'(8'h10 + i), PPN_W'(10'h200 + i), 3'd0);
  endtask

  task automatic expectHit(input string rq, input logic [VPN_W-1:0] v, input bit exp);
    look(v, 1'b0);
    chk(rq, {31'd0, gHit}, {31'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: nothing hits after reset
    expectHit("R1 reset miss vpn 00", 8'h00, 1'b0);
    expectHit("R1 reset miss vpn ff", 8'hFF, 1'b0);

    // R11: idle lookup never hits
    fill(8'h44, 10'h044, 3'd0);
    @(negedge clk); lkValid = 1'b0; lkVpn = 8'h44; #1
    chk("R11 idle no hit", {31'd0, lkHit}, 32'd0);
    expectHit("R2 plain fill hits", 8'h44, 1'b1);

    // R1: flush clears; flush with fill drops the fill
    flush();
    expectHit("R1 flushed miss", 8'h44, 1'b0);
    @(negedge clk);
    walkVpn = 8'h45; walkSizeLog = '0; walkDone = 1'b1; flushAll = 1'b1;
    #1 chk("R1 fill dropped under flush", {31'd0, fillTaken}, 32'd0);
    @(negedge clk); walkDone = 1'b0; flushAll = 1'b0;
    expectHit("R1 dropped fill miss", 8'h45, 1'b0);

    // R2: context tags
    flush();
    walkGv = 1; walkPscv = 1; walkGscid = 3'd5; walkPscid = 4'd9;
    fill(8'h33, 10'h133, 3'd0);
    lkGv = 1; lkPscv = 1; lkGscid = 3'd5; lkPscid = 4'd9;
    expectHit("R2 context exact hit", 8'h33, 1'b1);
    lkGv = 0;        expectHit("R2 GV mismatch", 8'h33, 1'b0); lkGv = 1;
    lkPscv = 0;      expectHit("R2 PSCV mismatch", 8'h33, 1'b0); lkPscv = 1;
    lkGscid = 3'd4;  expectHit("R2 GSCID mismatch", 8'h33, 1'b0); lkGscid = 3'd5;
    lkPscid = 4'd8;  expectHit("R2 PSCID mismatch", 8'h33, 1'b0); lkPscid = 4'd9;
    expectHit("R2 neighbour page miss", 8'h32, 1'b0);
    walkGv = 0; walkPscv = 0; walkGscid = '0; walkPscid = '0;
    lkGv = 0; lkPscv = 0; lkGscid = '0; lkPscid = '0;

    // R5: attributes and interrupt flag
    flush();
    walkAttr = 6'h2A; walkMsi = 1'b1; walkMrif = 1'b0;
    fill(8'h60, 10'h060, 3'd0);
    walkAttr = 6'h15; walkMsi = 1'b0;
    fill(8'h61, 10'h061, 3'd0);
    look(8'h60, 1'b0);
    chk("R5 attr entry a", {26'd0, gAttr}, 32'h2A);
    chk("R5 msi entry a", {31'd0, gMsi}, 32'd1);
    look(8'h61, 1'b0);
    chk("R5 attr entry b", {26'd0, gAttr}, 32'h15);
    chk("R5 msi entry b", {31'd0, gMsi}, 32'd0);
    walkAttr = '0;

    // R3, R4: every size order against every lookup page
    for (int k = 0; k < VPN_W; k++) begin
      logic [VPN_W-1:0] m;
      m = VPN_W'((1 << k) - 1);
      flush();
      fill(8'hB5, 10'h2C7, 3'(k));
      for (int v = 0; v < 256; v++) begin
        logic eh;
        logic [PPN_W-1:0] ep;
        eh = (((VPN_W'(v) ^ 8'hB5) & ~m) == '0);
        ep = (10'h2C7 & ~{2'b00, m}) | {2'b00, VPN_W'(v) & m};
        look(VPN_W'(v), 1'b0);
        chk("R3 napot coverage", {31'd0, gHit}, {31'd0, eh});
        if (eh) begin
          chk("R4 rebuilt ppn", {22'd0, gPpn}, {22'd0, ep});
          chk("R3 superpage flag", {31'd0, gSup}, {31'd0, (k > 0)});
        end
      end
    end

    // R6, R7, R8: fill policy sweep
    walkGv = 1; walkPscv = 1; walkGscid = 3'd3; walkPscid = 4'd9;
    lkGv = 1; lkGscid = 3'd3;
    for (int c = 0; c < 64; c++) begin
      logic expTaken, remap;
      flush();
      walkAts = c[0]; walkMsi = c[1]; walkMrif = c[2];
      walkT2gpa = c[3]; cfgFillT2gpa = c[4]; cfgFillAlways = c[5];
      walkGpn = 8'hC3;
      expTaken = !(c[1] && c[2]) && (!c[0] || (c[3] && c[4]) || c[5]);
      remap = c[0] && c[3];
      fill(8'h5A, 10'h111, 3'd0);
      chk(c[0] ? "R7 ats policy" : "R6 untranslated policy",
          {31'd0, gTaken}, {31'd0, expTaken});
      lkPscv  = remap ? 1'b0 : 1'b1;
      lkPscid = remap ? 4'd0 : 4'd9;
      expectHit(remap ? "R8 guest tag hit" : "R6 cached tag hit",
                remap ? 8'hC3 : 8'h5A, expTaken);
      if (remap && expTaken) begin
        lkPscv = 1; lkPscid = 4'd9;
        expectHit("R8 iova tag absent", 8'h5A, 1'b0);
      end
    end
    walkAts = 0; walkMsi = 0; walkMrif = 0; walkT2gpa = 0;
    cfgFillT2gpa = 0; cfgFillAlways = 0;
    walkGv = 0; walkPscv = 0; walkGscid = '0; walkPscid = '0;
    lkGv = 0; lkPscv = 0; lkGscid = '0; lkPscid = '0;

    // R9: free entries first, then least recently used
    fillFour();
    for (int i = 0; i < 4; i++) expectHit("R9 free entries used", VPN_W'(8'h10 + i), 1'b1);
    fillFour();
    look(8'h10, 1'b1);
    fill(8'h14, 10'h204, 3'd0);
    expectHit("R9 lru evicted", 8'h11, 1'b0);
    expectHit("R9 touched kept", 8'h10, 1'b1);
    expectHit("R9 kept c", 8'h12, 1'b1);
    expectHit("R9 kept d", 8'h13, 1'b1);
    expectHit("R9 new present", 8'h14, 1'b1);

    // R10: lookup hits the entry being replaced in the same cycle
    fillFour();
    fillLook(8'h14, 10'h204, 8'h10);
    chk("R10 pre-fill hit", {31'd0, gHit}, 32'd1);
    chk("R10 pre-fill ppn", {22'd0, gPpn}, 32'h200);
    expectHit("R10 victim gone", 8'h10, 1'b0);
    expectHit("R10 new entry", 8'h14, 1'b1);

    // R10: hit on another entry in a fill cycle is not a use
    fillFour();
    fillLook(8'h14, 10'h204, 8'h11);
    chk("R10 other hit", {31'd0, gHit}, 32'd1);
    fill(8'h15, 10'h205, 3'd0);
    expectHit("R10 untouched evicted", 8'h11, 1'b0);
    expectHit("R10 first victim gone", 8'h10, 1'b0);
    expectHit("R10 kept c", 8'h12, 1'b1);
    expectHit("R10 kept d", 8'h13, 1'b1);
    expectHit("R10 kept e", 8'h14, 1'b1);
    expectHit("R10 kept f", 8'h15, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog R1..: run hung actual=running expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule